// File: doc/BRIEF.md
# Bank-to-Bank Block Move Engine

This block copies a run of bytes from one memory bank to another over a simple synchronous byte-wide bus. A start command carries a two-byte operand that names both banks. The source offset, the destination offset and the byte count come from three 16-bit working-register inputs, which the block captures when it starts. The count is encoded as the number of bytes minus one.

The engine walks both offsets upward one byte at a time. For each byte it reads from the source bank, writes that byte to the destination bank, then advances the offsets and counts down. It stops after the count register wraps to all ones. At start it also loads a data-bank register with the destination bank. It reports a busy flag, a one-cycle done pulse, the final register values and a nominal cost of seven cycles for each byte moved.

The bus is synchronous. Read data is due in the cycle after a read strobe, and a write takes effect at the clock edge that ends the write-strobe cycle.

Top module: `blockMover`

## Requirements
- R1: The operand's low byte (bits 7:0) is the source bank and its high byte (bits 15:8) is the destination bank. Every read address is {source bank, X offset} and every write address is {destination bank, Y offset}, with the bank in address bits 23:16.
- R2: An accumulator value N captured at start moves exactly N+1 bytes, so N = 0 moves one byte.
- R3: Each byte takes one read cycle, then one write cycle, then one update cycle. memRd and memWr are never high together. done rises 3·(N+1)+1 cycles after the clock edge that accepts start.
- R4: While done is high, xOut = X0+N+1 and yOut = Y0+N+1 (both modulo 2^16), accOut = 0xFFFF and dataBankOut = the destination bank. These values hold after done.
- R5: The offsets wrap from 0xFFFF to 0x0000 without carrying into the bank byte. The bank byte stays the same for the whole transfer.
- R6: costOut equals 7·(N+1) from the cycle after start is accepted, and it stays stable until the next start.
- R7: busy is high from the cycle after start is accepted through the done cycle, and low after it. done lasts one cycle. A start while busy is ignored and changes neither the timing nor the results.
- R8: Under reset (rstN low) busy, done, memRd and memWr are low, and every register output reads zero.
- R9: The byte written in each write cycle is the byte returned by the read of the same iteration, so the destination receives the source bytes in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a move (taken only when idle) |
| operand | input | 16 | {destination bank, source bank} |
| xIn | input | 16 | Source offset at start |
| yIn | input | 16 | Destination offset at start |
| accIn | input | 16 | Byte count minus one |
| memAddr | output | 24 | Bus address {bank, offset} |
| memRd | output | 1 | Read strobe; data due next cycle |
| memWr | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| xOut | output | 16 | Current source offset |
| yOut | output | 16 | Current destination offset |
| accOut | output | 16 | Current count register |
| dataBankOut | output | 8 | Data-bank register |
| costOut | output | 19 | Nominal cost, 7 per byte |

## Verification
busy and costOut are due one cycle after the edge that accepts start. done and the final register values are due 3·(N+1)+1 cycles after that edge, and busy drops one cycle later. The bench counts falling edges from the accepting edge and samples each result at the count where it is due. A late or early done therefore counts as a failure, not as a wait. Bus traffic is logged at every rising edge and compared with the expected address and data sequence once the transfer ends.

// File: rtl/bmPkg.sv
package bmPkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WRITE  = 3'd2,
    ST_UPDATE = 3'd3,
    ST_DONE   = 3'd4
  } bmState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture operands and working registers
    logic readEn;   // drive source address with read strobe
    logic writeEn;  // drive destination address with write strobe
    logic step;     // advance offsets, count down
    logic finish;   // completion cycle
  } bmStrobes_t;

endpackage

// File: rtl/bmControl.sv
module bmControl
  import bmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastByte,
  output bmStrobes_t stb,
  output logic       busy,
  output logic       done
);

  bmState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (start) stateD = ST_READ;
      ST_READ:   stateD = ST_WRITE;
      ST_WRITE:  stateD = ST_UPDATE;
      ST_UPDATE: stateD = lastByte ? ST_DONE : ST_READ;
      ST_DONE:   stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.load    = (stateQ == ST_IDLE) && start;
    stb.readEn  = (stateQ == ST_READ);
    stb.writeEn = (stateQ == ST_WRITE);
    stb.step    = (stateQ == ST_UPDATE);
    stb.finish  = (stateQ == ST_DONE);
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = stb.finish;

endmodule

// File: rtl/bmDatapath.sv
module bmDatapath
  import bmPkg::*;
#(
  parameter int OFF_W         = 16,
  parameter int BANK_W        = 8,
  parameter int DATA_W        = 8,
  parameter int COST_PER_BYTE = 7,
  localparam int ADDR_W       = BANK_W + OFF_W,
  localparam int COST_W       = OFF_W + $clog2(COST_PER_BYTE + 1)
)(
  input  logic                clk,
  input  logic                rstN,
  input  bmStrobes_t          stb,
  input  logic [2*BANK_W-1:0] operand,
  input  logic [OFF_W-1:0]    xIn,
  input  logic [OFF_W-1:0]    yIn,
  input  logic [OFF_W-1:0]    accIn,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRd,
  output logic                memWr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                lastByte,
  output logic [OFF_W-1:0]    xOut,
  output logic [OFF_W-1:0]    yOut,
  output logic [OFF_W-1:0]    accOut,
  output logic [BANK_W-1:0]   dataBankOut,
  output logic [COST_W-1:0]   costOut
);

  logic [OFF_W-1:0]  xQ, yQ, accQ;
  logic [BANK_W-1:0] srcBankQ, dstBankQ;
  logic [COST_W-1:0] costQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xQ       <= '0;
      yQ       <= '0;
      accQ     <= '0;
      srcBankQ <= '0;
      dstBankQ <= '0;
      costQ    <= '0;
    end else if (stb.load) begin
      xQ       <= xIn;
      yQ       <= yIn;
      accQ     <= accIn;
      srcBankQ <= operand[BANK_W-1:0];
      dstBankQ <= operand[2*BANK_W-1:BANK_W];
      costQ    <= COST_W'(COST_PER_BYTE) * (COST_W'(accIn) + COST_W'(1));
    end else if (stb.step) begin
      // offsets wrap inside their bank; the count wraps to all ones at the end
      xQ   <= xQ + OFF_W'(1);
      yQ   <= yQ + OFF_W'(1);
      accQ <= accQ - OFF_W'(1);
    end
  end

  assign lastByte    = (accQ == '0);
  assign memAddr     = stb.readEn ? {srcBankQ, xQ} :
                       stb.writeEn ? {dstBankQ, yQ} : '0;
  assign memRd       = stb.readEn;
  assign memWr       = stb.writeEn;
  assign memWdata    = stb.writeEn ? memRdata : '0;
  assign xOut        = xQ;
  assign yOut        = yQ;
  assign accOut      = accQ;
  assign dataBankOut = dstBankQ;
  assign costOut     = costQ;

endmodule

// File: rtl/blockMover.sv
module blockMover
  import bmPkg::*;
#(
  parameter int OFF_W         = 16,
  parameter int BANK_W        = 8,
  parameter int DATA_W        = 8,
  parameter int COST_PER_BYTE = 7,
  localparam int ADDR_W       = BANK_W + OFF_W,
  localparam int COST_W       = OFF_W + $clog2(COST_PER_BYTE + 1)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2*BANK_W-1:0] operand,
  input  logic [OFF_W-1:0]    xIn,
  input  logic [OFF_W-1:0]    yIn,
  input  logic [OFF_W-1:0]    accIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRd,
  output logic                memWr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                busy,
  output logic                done,
  output logic [OFF_W-1:0]    xOut,
  output logic [OFF_W-1:0]    yOut,
  output logic [OFF_W-1:0]    accOut,
  output logic [BANK_W-1:0]   dataBankOut,
  output logic [COST_W-1:0]   costOut
);

  bmStrobes_t stb;
  logic       lastByte;

  bmControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastByte (lastByte),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  bmDatapath #(
    .OFF_W         (OFF_W),
    .BANK_W        (BANK_W),
    .DATA_W        (DATA_W),
    .COST_PER_BYTE (COST_PER_BYTE)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .operand     (operand),
    .xIn         (xIn),
    .yIn         (yIn),
    .accIn       (accIn),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memRd       (memRd),
    .memWr       (memWr),
    .memWdata    (memWdata),
    .lastByte    (lastByte),
    .xOut        (xOut),
    .yOut        (yOut),
    .accOut      (accOut),
    .dataBankOut (dataBankOut),
    .costOut     (costOut)
  );

endmodule

// File: rtl/bmChecker.sv
module bmChecker #(
  parameter int OFF_W  = 16,
  parameter int BANK_W = 8,
  parameter int ADDR_W = 24,
  parameter int COST_W = 19
)(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic              busy,
  input logic              done,
  input logic [OFF_W-1:0]  accOut,
  input logic [BANK_W-1:0] dataBankOut,
  input logic [COST_W-1:0] costOut
);

  p_rd_wr_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> memWr);

  p_write_after_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  p_busy_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRd && !memWr));

  p_done_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (accOut == {OFF_W{1'b1}}));

  p_write_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (memAddr[ADDR_W-1:OFF_W] == dataBankOut));

  p_cost_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(costOut));

endmodule

bind blockMover bmChecker #(
  .OFF_W  (OFF_W),
  .BANK_W (BANK_W),
  .ADDR_W (ADDR_W),
  .COST_W (COST_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .memAddr     (memAddr),
  .memRd       (memRd),
  .memWr       (memWr),
  .busy        (busy),
  .done        (done),
  .accOut      (accOut),
  .dataBankOut (dataBankOut),
  .costOut     (costOut)
);

// File: tb/tb_blockMover.sv
module tb_blockMover;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] operand = '0, xIn = '0, yIn = '0, accIn = '0;
  logic [23:0] memAddr;
  logic        memRd, memWr, busy, done;
  logic [7:0]  memWdata, memRdata;
  logic [15:0] xOut, yOut, accOut;
  logic [7:0]  dataBankOut;
  logic [18:0] costOut;

  always #5 clk = ~clk;

  blockMover dut (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand),
    .xIn(xIn), .yIn(yIn), .accIn(accIn),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done),
    .xOut(xOut), .yOut(yOut), .accOut(accOut),
    .dataBankOut(dataBankOut), .costOut(costOut)
  );

  int checks = 0;
  int errors = 0;

  // memory model: unwritten bytes follow a pattern of their address
  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] + a[15:8] * 8'd5 + a[23:16] * 8'd11;
  endfunction

  logic [7:0]  store [logic [23:0]];
  logic [23:0] wrA [512];
  logic [7:0]  wrD [512];
  int          wrN = 0;
  logic [7:0]  expSrc = '0;
  int          rdBad = 0;
  int          ovl = 0;

  always @(posedge clk) begin
    if (memRd) begin
      memRdata <= store.exists(memAddr) ? store[memAddr] : pat(memAddr);
      if (memAddr[23:16] != expSrc) rdBad++;
    end
    if (memRd && memWr) ovl++;
    if (memWr) begin
      store[memAddr] = memWdata;
      if (wrN < 512) begin
        wrA[wrN] = memAddr;
        wrD[wrN] = memWdata;
      end
      wrN++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {srcBank, dstBank, x, y, acc}
  localparam logic [63:0] VECS [4] = '{
    {8'h01, 8'h02, 16'h1000, 16'h2000, 16'h0003},
    {8'h10, 8'h20, 16'h0000, 16'h0000, 16'h0000},
    {8'h03, 8'h04, 16'hFFFE, 16'hFFFD, 16'h0004},
    {8'h7F, 8'h80, 16'h1234, 16'h00FF, 16'h0010}
  };

  task automatic runVec(input logic [63:0] v, input bit inject);
    logic [7:0]  sb = v[63:56];
    logic [7:0]  db = v[55:48];
    logic [15:0] x0 = v[47:32];
    logic [15:0] y0 = v[31:16];
    logic [15:0] n  = v[15:0];
    int nb = int'(n) + 1;
    int cnt;
    @(negedge clk);
    wrN = 0; rdBad = 0; ovl = 0; expSrc = sb;
    operand = {db, sb}; xIn = x0; yIn = y0; accIn = n;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    operand = 16'h5A5A; xIn = 16'h7777; yIn = 16'h8888; accIn = 16'h0002;
    cnt = 1;
    check(busy == 1'b1, "R7", "busy after start", busy, 1);
    check(costOut == 19'(7 * nb), "R6", "cost", costOut, 7 * nb);
    while (!done && cnt < 3 * nb + 20) begin
      start = inject && (cnt == 4);
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(cnt == 3 * nb + 1, "R3", "done cycle", cnt, 3 * nb + 1);
    check(xOut == x0 + 16'(nb), "R4", "final x", xOut, x0 + 16'(nb));
    check(yOut == y0 + 16'(nb), "R4", "final y", yOut, y0 + 16'(nb));
    check(accOut == 16'hFFFF, "R4", "final acc", accOut, 16'hFFFF);
    check(dataBankOut == db, "R4", "data bank", dataBankOut, db);
    check(costOut == 19'(7 * nb), "R6", "cost at done", costOut, 7 * nb);
    @(negedge clk);
    check(!done && !busy, "R7", "done one cycle, busy low", {done, busy}, 0);
    check(xOut == x0 + 16'(nb), "R4", "x held", xOut, x0 + 16'(nb));
    check(wrN == nb, "R2", "bytes moved", wrN, nb);
    check(rdBad == 0, "R1", "reads outside source bank", rdBad, 0);
    check(ovl == 0, "R3", "read and write overlap", ovl, 0);
    for (int i = 0; i < nb && i < 512; i++) begin
      logic [23:0] ea = {db, y0 + 16'(i)};
      logic [7:0]  ed = pat({sb, x0 + 16'(i)});
      check(wrA[i] == ea, "R5", "write address", wrA[i], ea);
      check(wrD[i] == ed, "R9", "write data", wrD[i], ed);
    end
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRd && !memWr, "R8", "controls in reset",
          {busy, done, memRd, memWr}, 0);
    check(xOut == 0 && yOut == 0 && accOut == 0 && dataBankOut == 0 && costOut == 0,
          "R8", "registers in reset", accOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy, "R8", "idle after reset", busy, 0);

    foreach (VECS[i]) runVec(VECS[i], 1'b0);

    // R7: start while busy is ignored
    runVec(VECS[0], 1'b1);
    // R2: zero count moves a single byte (repeat after the ignored start)
    runVec(VECS[1], 1'b0);

    // R8: reset in the middle of a transfer
    @(negedge clk);
    operand = 16'h0506; xIn = 16'h0100; yIn = 16'h0200; accIn = 16'h0020;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!busy && !memRd && !memWr && accOut == 0, "R8", "mid-run reset",
          {busy, memRd, memWr}, 0);
    rstN = 1'b1;
    runVec(VECS[2], 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule